// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit turns the operands of one load or store into the memory address to access and the new value for the base register. The offset is either a 12-bit unsigned immediate or a register value that can first go through a barrel shift. The offset is added to or subtracted from the base. The addressing mode decides three things: whether the sum or the untouched base becomes the address, whether the sum is written back to the base register, and whether the program counter replaces the base.

All results are captured in one register stage. They appear on the cycle after the input strobe. A word access whose address is not 4-byte aligned raises a fault, and a faulting access never requests a base update. Decode, register-file storage and the memory access itself are left to the surrounding pipeline.

Top module: `agu_top`

## Requirements
- R1: Mode code 0 (zero offset): the address equals `base`, `wb_en` is 0 and `wb_value` equals `base`.
- R2: Mode code 1 (pre-indexed): the address equals base combined with the offset, `wb_en` is 0 and `wb_value` equals `base`.
- R3: Mode code 2 (pre-indexed with update): the address equals base combined with the offset, `wb_value` equals that same address, and `wb_en` is 1 unless the access faults.
- R4: Mode code 3 (post-indexed): the address equals `base`, `wb_value` equals base combined with the offset, and `wb_en` is 1 unless the access faults. For example, base 0x100 with immediate 8 subtracted gives a written-back value of 0xF8.
- R5: Mode code 4 (PC-relative): the address equals `pc` combined with the offset, `wb_en` is 0 and `wb_value` equals `base`.
- R6: When `off_is_reg` is 0, the offset is `imm` zero-extended, covering 0 to 4095, and the shift fields have no effect. When `off_is_reg` is 1, the offset is `off_reg` shifted by `shift_amt` (0 to 31) according to `shift_kind`: 0 is a logical left shift, 1 is a logical right shift, 2 is an arithmetic right shift and 3 is a rotate right. An amount of 0 leaves the value unchanged.
- R7: "Combined with the offset" means base plus offset when `sub_en` is 0 and base minus offset when `sub_en` is 1, both modulo 2^32.
- R8: `misalign` is 1 exactly when `size_byte` is 0 and address bits [1:0] are nonzero. A byte access (`size_byte` = 1) never faults.
- R9: Whenever `misalign` is 1, `wb_en` is 0.
- R10: Outputs are registered. `out_valid` is 1 on the cycle after a cycle with `in_valid` high, and 0 otherwise. Without a strobe, `wb_en` and `misalign` are 0 and `addr` and `wb_value` keep their last values.
- R11: While `rst_n` is low, every output is 0.
- R12: Mode codes 5, 6 and 7 behave exactly as mode code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: the operands on this cycle form one access |
| base | input | 32 | Base register value |
| pc | input | 32 | Current program counter, used as base in mode 4 |
| imm | input | 12 | Unsigned immediate offset |
| off_reg | input | 32 | Register offset value |
| off_is_reg | input | 1 | 1 selects the shifted register offset, 0 the immediate |
| shift_kind | input | 2 | Shift type for the register offset |
| shift_amt | input | 5 | Shift amount for the register offset |
| sub_en | input | 1 | 1 subtracts the offset, 0 adds it |
| mode | input | 3 | Addressing mode code |
| size_byte | input | 1 | 1 for byte access, 0 for word access |
| out_valid | output | 1 | Results valid this cycle |
| addr | output | 32 | Effective address |
| wb_en | output | 1 | Base register update request |
| wb_value | output | 32 | Value for the base register |
| misalign | output | 1 | Word alignment fault |

## Verification
The sweep crosses every mode code and every shift kind with edge amounts, both directions, both sizes and bases that sit next to the wrap points. The following faults are caught:
- A design that mixes up pre- and post-indexing puts the sum on the wrong output.
- One that checks alignment on the base instead of the final address flags the wrong accesses in the pre-indexed modes.
- One that forgets to gate writeback on a fault requests a base update for a faulting access.
- Rotate versus arithmetic shift errors show up as wrong high bits whenever the offset's top bit is set.
- An immediate that is sign-extended instead of zero-extended is wrong at 4095.
- Reserved mode codes that fall through to another mode produce a writeback or a PC-based address.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    AM_ZERO   = 3'd0,
    AM_PRE    = 3'd1,
    AM_PRE_WB = 3'd2,
    AM_POST   = 3'd3,
    AM_PCREL  = 3'd4
  } agu_mode_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } agu_shift_e;

endpackage

// File: rtl/agu_offset_sel.sv
module agu_offset_sel
  import agu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 12,
  parameter int SHAMT_W = 5
) (
  input  logic [IMM_W-1:0]   imm,
  input  logic [DATA_W-1:0]  reg_val,
  input  logic               is_reg,
  input  agu_shift_e         kind,
  input  logic [SHAMT_W-1:0] amt,
  output logic [DATA_W-1:0]  offset
);

  localparam int PAD_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] barrel(
    input logic [DATA_W-1:0]  v,
    input agu_shift_e         k,
    input logic [SHAMT_W-1:0] n
  );
    logic [2*DATA_W-1:0] dbl;
    logic [DATA_W-1:0]   r;
    dbl = {v, v} >> n;
    case (k)
      SH_LSL:  r = v << n;
      SH_LSR:  r = v >> n;
      SH_ASR:  r = $unsigned($signed(v) >>> n);
      default: r = dbl[DATA_W-1:0];
    endcase
    return r;
  endfunction

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] reg_shifted;

  assign imm_ext     = {{PAD_W{1'b0}}, imm};
  assign reg_shifted = barrel(reg_val, kind, amt);
  assign offset      = is_reg ? reg_shifted : imm_ext;

endmodule

// File: rtl/agu_sum.sv
module agu_sum #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] y
);

  function automatic logic [DATA_W-1:0] add_or_sub(
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] z,
    input logic              s
  );
    return s ? (x - z) : (x + z);
  endfunction

  assign y = add_or_sub(a, b, sub);

endmodule

// File: rtl/agu_mode_ctrl.sv
module agu_mode_ctrl
  import agu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ALIGN_W = 2
) (
  input  agu_mode_e         mode,
  input  logic              size_byte,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] wb_value,
  output logic              wb_req,
  output logic              fault
);

  always_comb begin
    addr     = base;
    wb_value = base;
    wb_req   = 1'b0;
    case (mode)
      AM_PRE: addr = sum;
      AM_PRE_WB: begin
        addr     = sum;
        wb_value = sum;
        wb_req   = 1'b1;
      end
      AM_POST: begin
        wb_value = sum;
        wb_req   = 1'b1;
      end
      AM_PCREL: addr = sum;
      default: ;
    endcase
  end

  assign fault = !size_byte && (addr[ALIGN_W-1:0] != '0);

endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [DATA_W-1:0]         base,
  input  logic [DATA_W-1:0]         pc,
  input  logic [IMM_W-1:0]          imm,
  input  logic [DATA_W-1:0]         off_reg,
  input  logic                      off_is_reg,
  input  logic [1:0]                shift_kind,
  input  logic [$clog2(DATA_W)-1:0] shift_amt,
  input  logic                      sub_en,
  input  logic [2:0]                mode,
  input  logic                      size_byte,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         addr,
  output logic                      wb_en,
  output logic [DATA_W-1:0]         wb_value,
  output logic                      misalign
);

  localparam int SHAMT_W = $clog2(DATA_W);

  agu_mode_e         mode_q;
  logic [DATA_W-1:0] nx_offset;
  logic [DATA_W-1:0] nx_base_sel;
  logic [DATA_W-1:0] nx_sum;
  logic [DATA_W-1:0] nx_addr;
  logic [DATA_W-1:0] nx_wb_value;
  logic              nx_wb_req;
  logic              nx_fault;

  assign mode_q      = agu_mode_e'(mode);
  assign nx_base_sel = (mode_q == AM_PCREL) ? pc : base;

  agu_offset_sel #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .SHAMT_W(SHAMT_W)
  ) u_offset (
    .imm    (imm),
    .reg_val(off_reg),
    .is_reg (off_is_reg),
    .kind   (agu_shift_e'(shift_kind)),
    .amt    (shift_amt),
    .offset (nx_offset)
  );

  agu_sum #(.DATA_W(DATA_W)) u_sum (
    .a  (nx_base_sel),
    .b  (nx_offset),
    .sub(sub_en),
    .y  (nx_sum)
  );

  agu_mode_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .mode     (mode_q),
    .size_byte(size_byte),
    .base     (base),
    .sum      (nx_sum),
    .addr     (nx_addr),
    .wb_value (nx_wb_value),
    .wb_req   (nx_wb_req),
    .fault    (nx_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      addr      <= '0;
      wb_en     <= 1'b0;
      wb_value  <= '0;
      misalign  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        addr     <= nx_addr;
        wb_value <= nx_wb_value;
        wb_en    <= nx_wb_req && !nx_fault;
        misalign <= nx_fault;
      end else begin
        wb_en    <= 1'b0;
        misalign <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/agu_checker.sv
module agu_checker
  import agu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        mode,
  input logic              size_byte,
  input logic [DATA_W-1:0] base,
  input logic              nx_fault,
  input logic              out_valid,
  input logic [DATA_W-1:0] addr,
  input logic              wb_en,
  input logic [DATA_W-1:0] wb_value,
  input logic              misalign
);

  assert_strobe_to_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wb_en && !misalign));

  assert_zero_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == AM_ZERO) |=> (addr == $past(base) && !wb_en));

  assert_post_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == AM_POST && !nx_fault) |=> (addr == $past(base) && wb_en));

  assert_prewb_same_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == AM_PRE_WB) |=> (wb_value == addr));

  assert_fault_blocks_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nx_fault) |=> (misalign && !wb_en));

  assert_byte_no_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_byte) |=> !misalign);

  assert_fault_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (addr[1:0] != 2'b00));

endmodule

bind agu_top agu_checker #(.DATA_W(DATA_W)) u_agu_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .mode     (mode),
  .size_byte(size_byte),
  .base     (base),
  .nx_fault (nx_fault),
  .out_valid(out_valid),
  .addr     (addr),
  .wb_en    (wb_en),
  .wb_value (wb_value),
  .misalign (misalign)
);

// File: tb/agu_top_bench.sv
module agu_top_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] base = '0;
  logic [31:0] pc = '0;
  logic [11:0] imm = '0;
  logic [31:0] off_reg = '0;
  logic        off_is_reg = 1'b0;
  logic [1:0]  shift_kind = '0;
  logic [4:0]  shift_amt = '0;
  logic        sub_en = 1'b0;
  logic [2:0]  mode = '0;
  logic        size_byte = 1'b0;
  logic        out_valid;
  logic [31:0] addr;
  logic        wb_en;
  logic [31:0] wb_value;
  logic        misalign;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agu_top u_agu_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base(base), .pc(pc),
    .imm(imm), .off_reg(off_reg), .off_is_reg(off_is_reg),
    .shift_kind(shift_kind), .shift_amt(shift_amt), .sub_en(sub_en),
    .mode(mode), .size_byte(size_byte), .out_valid(out_valid), .addr(addr),
    .wb_en(wb_en), .wb_value(wb_value), .misalign(misalign)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R6 model: the shift is written as a 64-bit window so it stays independent of the RTL
  function automatic logic [31:0] model_offset(input logic isr, input logic [11:0] im,
      input logic [31:0] rv, input logic [1:0] k, input logic [4:0] n);
    logic [63:0] w;
    if (!isr) return {20'd0, im};
    case (k)
      2'd0: w = {32'd0, rv} << n;
      2'd1: w = {32'd0, rv} >> n;
      2'd2: w = {{32{rv[31]}}, rv} >> n;
      default: w = {rv, rv} >> n;
    endcase
    return w[31:0];
  endfunction

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R12";
    endcase
  endfunction

  // Drives one access, waits one cycle, compares all result fields (R10 latency)
  task automatic apply(input logic [31:0] b, input logic [31:0] p, input logic [11:0] im,
      input logic [31:0] rv, input logic isr, input logic [1:0] k, input logic [4:0] n,
      input logic s, input logic [2:0] m, input logic by);
    logic [31:0] off, comb, e_addr, e_wbv;
    logic        e_wbreq, e_fault;
    string       t;
    off  = model_offset(isr, im, rv, k, n);
    comb = (m == 3'd4) ? (s ? p - off : p + off) : (s ? b - off : b + off); // R7
    e_addr = b; e_wbv = b; e_wbreq = 1'b0;
    if (m == 3'd1 || m == 3'd4) e_addr = comb;
    if (m == 3'd2) begin e_addr = comb; e_wbv = comb; e_wbreq = 1'b1; end
    if (m == 3'd3) begin e_wbv = comb; e_wbreq = 1'b1; end
    e_fault = !by && (e_addr % 4 != 0);
    t = mode_tag(m);
    base = b; pc = p; imm = im; off_reg = rv; off_is_reg = isr; shift_kind = k;
    shift_amt = n; sub_en = s; mode = m; size_byte = by; in_valid = 1'b1;
    @(negedge clk);
    check({t, " out_valid R10"}, {31'd0, out_valid}, 32'd1);
    check({t, " addr (R6 R7)"}, addr, e_addr);
    check({t, " wb_value (R6 R7)"}, wb_value, e_wbv);
    check(e_fault ? "R9 wb_en" : {t, " wb_en"}, {31'd0, wb_en}, {31'd0, e_wbreq && !e_fault});
    check("R8 misalign", {31'd0, misalign}, {31'd0, e_fault});
  endtask

  function automatic logic [31:0] pick_base(input int i);
    case (i)
      0: return 32'h0000_1000;
      1: return 32'h8000_0003;
      2: return 32'hFFFF_FFFE;
      default: return 32'h0000_0005;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held_a, held_w;
    repeat (3) @(negedge clk);
    // R11: outputs cleared under reset
    check("R11 out_valid", {31'd0, out_valid}, 32'd0);
    check("R11 addr", addr, 32'd0);
    check("R11 wb_en", {31'd0, wb_en}, 32'd0);
    check("R11 wb_value", wb_value, 32'd0);
    check("R11 misalign", {31'd0, misalign}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners: R4 decrement by 8, R6 largest immediate, R5 PC base
    apply(32'h0000_0100, 32'h0, 12'd8, 32'h0, 1'b0, 2'd0, 5'd0, 1'b1, 3'd3, 1'b0);
    check("R4 example", wb_value, 32'h0000_00F8);
    apply(32'h0000_0000, 32'h0, 12'hFFF, 32'h0, 1'b0, 2'd3, 5'd9, 1'b0, 3'd1, 1'b1);
    check("R6 imm max", addr, 32'd4095);
    apply(32'h1234_0000, 32'h0000_4000, 12'h010, 32'h0, 1'b0, 2'd0, 5'd0, 1'b0, 3'd4, 1'b0);
    check("R5 pc base", addr, 32'h0000_4010);

    // R10: hold behaviour on an idle cycle
    held_a = addr; held_w = wb_value;
    in_valid = 1'b0;
    @(negedge clk);
    check("R10 idle out_valid", {31'd0, out_valid}, 32'd0);
    check("R10 idle addr hold", addr, held_a);
    check("R10 idle wb_value hold", wb_value, held_w);

    // Sweep: every mode code (R1 R2 R3 R4 R5 R12), shift kinds (R6), directions (R7), sizes (R8)
    for (int m = 0; m < 8; m++)
      for (int by = 0; by < 2; by++)
        for (int s = 0; s < 2; s++)
          for (int isr = 0; isr < 2; isr++)
            for (int k = 0; k < 4; k++)
              for (int ai = 0; ai < 5; ai++)
                for (int bi = 0; bi < 4; bi++) begin
                  logic [4:0] n;
                  case (ai)
                    0: n = 5'd0; 1: n = 5'd1; 2: n = 5'd2; 3: n = 5'd7; default: n = 5'd31;
                  endcase
                  apply(pick_base(bi), 32'h0000_2002 + 32'(bi * 4),
                        (bi == 0) ? 12'hFFF : 12'(12'h0A0 + bi),
                        32'hC000_0F06 ^ {bi[3:0], 24'd0, bi[3:0], 4'd0},
                        isr[0], k[1:0], n, s[0], m[2:0], by[0]);
                end

    in_valid = 1'b0;
    @(negedge clk);
    check("R10 final idle wb_en", {31'd0, wb_en}, 32'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule